// File: doc/BRIEF.md
# Multi-Target Bus Transaction Router

This block sits on the controller side of a two-wire multi-drop serial bus. A byte-level transaction front end hands it single-cycle events: START or repeated START with an address, a written byte, a read request, STOP, and NACK. The router decides which of `N_TGT` target engines take part in the current transfer, fans each event out to them, and returns one merged ACK/NACK or read byte to the front end. It also tracks bus-wide command state. It records whether the last START was addressed to the broadcast address (0x7E). It captures the common-command code carried by the first byte after a broadcast START. It also tracks whether a dynamic-address-assignment sequence (command 0x07) is in progress.

Each target engine reports combinationally whether it answers the address on `ev_addr`. It also reports whether it rejects the byte on `ev_wdata` and what its read byte is. Every router output is registered. A response or event pulse appears in the clock cycle after the event input that caused it. Only one event input is pulsed in any cycle.

During address assignment, several unassigned targets may answer the same broadcast START. The router then admits only the lowest-indexed one, which stands in for identifier arbitration. A STOP ends the whole sequence and reaches every attached target.

Top module: `tgt_route_hub`

## Requirements
- R1: After reset, `bus_bcast`, `bus_ccc`, `bus_daa` and `busy` are 0, all target pulse outputs are 0, `resp_valid` and `resp_nack` are 0, `bus_ccc_code` is 0x00 and `rd_data` is 0xFF.
- R2: A START to address 0x7E sets `bus_bcast`. If no assignment sequence is active, it also clears `bus_ccc`. A START to any other address clears `bus_bcast`.
- R3: On every START the participant set (bit i = target i) is rebuilt from `tgt_match`. Those targets get a `tgt_start` pulse. `resp_nack` is 1 exactly when the new set is empty.
- R4: A write with `bus_bcast` = 1 and `bus_ccc` = 0 latches its byte into `bus_ccc_code` and sets `bus_ccc`. If that byte is 0x07, it also sets `bus_daa`.
- R5: An active command survives a repeated START to a non-broadcast address and ends on a broadcast START. The assignment sequence (and its command) ends only on STOP.
- R6: While `bus_daa` = 1, a broadcast START admits only the lowest-indexed matching target. A non-broadcast START admits no target and is NACKed.
- R7: A write pulses `tgt_wr` for every participant with the byte on `tgt_wdata`. `tgt_ccc_mode` shows whether that byte belongs to a command, counting a byte that opens one.
- R8: A write's `resp_nack` is the OR of participant `tgt_wr_nak` bits, with one exception: inside a command whose code is below 0x80 (a broadcast command), target NACKs are ignored.
- R9: A read returns the byte of the lowest-indexed participant, or 0xFF when there is none, with `resp_nack` = 0.
- R10: STOP pulses `tgt_stop` for all targets while `bus_daa` = 1, and otherwise for the participants only. It then clears the participant set, all three flags and `bus_ccc_code`.
- R11: A NACK event pulses `tgt_nack_ev` for the participants and leaves the participant set unchanged.
- R12: `busy` is 1 exactly when the participant set is non-empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_start | input | 1 | START / repeated START event |
| ev_addr | input | 7 | Address carried by the START |
| ev_write | input | 1 | Write byte event |
| ev_wdata | input | 8 | Byte being written |
| ev_read | input | 1 | Read byte request |
| ev_stop | input | 1 | STOP event |
| ev_nack | input | 1 | Controller NACK event |
| tgt_match | input | N_TGT | Per-target address match for `ev_addr` |
| tgt_wr_nak | input | N_TGT | Per-target rejection of `ev_wdata` |
| tgt_rdata | input | 8*N_TGT | Per-target read byte, target i in bits [8i+7:8i] |
| resp_valid | output | 1 | Response for the previous START, write or read |
| resp_nack | output | 1 | Merged NACK for that response |
| rd_data | output | 8 | Read byte |
| tgt_start | output | N_TGT | START pulse to the new participants |
| tgt_wr | output | N_TGT | Write pulse to the participants |
| tgt_wdata | output | 8 | Byte forwarded with `tgt_wr` |
| tgt_ccc_mode | output | 1 | Forwarded byte belongs to a command |
| tgt_stop | output | N_TGT | STOP pulse |
| tgt_nack_ev | output | N_TGT | NACK pulse to the participants |
| busy | output | 1 | At least one participant |
| bus_bcast | output | 1 | Last START was broadcast |
| bus_ccc | output | 1 | Command active |
| bus_daa | output | 1 | Address assignment sequence active |
| bus_ccc_code | output | 8 | Latched command code |

## Verification
The bench runs an assignment sequence in which a repeated broadcast START must keep the command alive. A design that cleared it there would drop `bus_daa` and stop selecting one target. Inside that sequence, a START to a plain address must be refused. A STOP must then reach targets that already left the set; a design that kept only the participants would leave them without the STOP. The bench sends a target NACK under a broadcast command (below 0x80) and under a direct one (0x80 and above), and expects the first to be dropped and the second forwarded. Reads check the choice of the lowest participant and the 0xFF returned with no participant.

// File: rtl/hub_pkg.sv
package hub_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 7;
    localparam logic [ADDR_W-1:0] BCAST_ADDR = 7'h7E;
    localparam logic [BYTE_W-1:0] DAA_CODE = 8'h07;
    localparam logic [BYTE_W-1:0] IDLE_READ = 8'hFF;

    typedef logic [BYTE_W-1:0] hub_byte_t;

    typedef struct packed {
        logic bcast;
        logic ccc;
        logic daa;
    } hub_flags_t;

    // Commands at or above this code address one target directly.
    function automatic logic is_direct(input hub_byte_t code);
        return code[BYTE_W-1];
    endfunction
endpackage

// File: rtl/hub_lowest_pick.sv
module hub_lowest_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);
    logic [N:0] seen;
    assign seen[0] = 1'b0;
    for (genvar i = 0; i < N; i++) begin : g_pick
        assign grant[i]  = req[i] & ~seen[i];
        assign seen[i+1] = seen[i] | req[i];
    end
endmodule

// File: rtl/hub_rd_mux.sv
module hub_rd_mux
    import hub_pkg::*;
#(
    parameter int N = 4
) (
    input  logic [N-1:0]        part,
    input  logic [N*BYTE_W-1:0] rdata,
    output hub_byte_t           dout
);
    logic [N-1:0] first;
    hub_byte_t    acc [N+1];

    hub_lowest_pick #(.N(N)) u_first (.req(part), .grant(first));

    assign acc[0] = '0;
    for (genvar i = 0; i < N; i++) begin : g_or
        assign acc[i+1] = acc[i] | (rdata[i*BYTE_W +: BYTE_W] & {BYTE_W{first[i]}});
    end

    assign dout = (|part) ? acc[N] : IDLE_READ;
endmodule

// File: rtl/hub_nak_merge.sv
module hub_nak_merge
    import hub_pkg::*;
#(
    parameter int N = 4
) (
    input  logic [N-1:0] part,
    input  logic [N-1:0] nak,
    input  logic         in_ccc,
    input  hub_byte_t    code,
    output logic         nack
);
    logic any_nak;
    assign any_nak = |(part & nak);
    // Broadcast commands never fail on a target's refusal.
    assign nack = any_nak & (~in_ccc | is_direct(code));
endmodule

// File: rtl/tgt_route_hub.sv
module tgt_route_hub
    import hub_pkg::*;
#(
    parameter int N_TGT = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ev_start,
    input  logic [ADDR_W-1:0]       ev_addr,
    input  logic                    ev_write,
    input  logic [BYTE_W-1:0]       ev_wdata,
    input  logic                    ev_read,
    input  logic                    ev_stop,
    input  logic                    ev_nack,
    input  logic [N_TGT-1:0]        tgt_match,
    input  logic [N_TGT-1:0]        tgt_wr_nak,
    input  logic [N_TGT*BYTE_W-1:0] tgt_rdata,
    output logic                    resp_valid,
    output logic                    resp_nack,
    output logic [BYTE_W-1:0]       rd_data,
    output logic [N_TGT-1:0]        tgt_start,
    output logic [N_TGT-1:0]        tgt_wr,
    output logic [BYTE_W-1:0]       tgt_wdata,
    output logic                    tgt_ccc_mode,
    output logic [N_TGT-1:0]        tgt_stop,
    output logic [N_TGT-1:0]        tgt_nack_ev,
    output logic                    busy,
    output logic                    bus_bcast,
    output logic                    bus_ccc,
    output logic                    bus_daa,
    output logic [BYTE_W-1:0]       bus_ccc_code
);
    localparam logic [N_TGT-1:0] ALL_TGT = {N_TGT{1'b1}};

    typedef struct packed {
        hub_flags_t       fl;
        hub_byte_t        code;
        logic [N_TGT-1:0] part;
        logic             rvalid;
        logic             rnack;
        hub_byte_t        rdat;
        logic [N_TGT-1:0] p_start;
        logic [N_TGT-1:0] p_wr;
        hub_byte_t        wdat;
        logic             wccc;
        logic [N_TGT-1:0] p_stop;
        logic [N_TGT-1:0] p_nack;
    } hub_state_t;

    localparam hub_state_t RST_ST = '{
        fl: '0, code: '0, part: '0, rvalid: 1'b0, rnack: 1'b0,
        rdat: IDLE_READ, p_start: '0, p_wr: '0, wdat: '0, wccc: 1'b0,
        p_stop: '0, p_nack: '0
    };

    hub_state_t st_q, st_d;

    logic [N_TGT-1:0] lowest_match;
    hub_byte_t        mux_byte;
    logic             wr_opens;
    logic             wr_in_ccc;
    hub_byte_t        wr_code;
    logic             wr_nack;

    hub_lowest_pick #(.N(N_TGT)) u_pick (
        .req   (tgt_match),
        .grant (lowest_match)
    );

    hub_rd_mux #(.N(N_TGT)) u_rdmux (
        .part  (st_q.part),
        .rdata (tgt_rdata),
        .dout  (mux_byte)
    );

    assign wr_opens  = st_q.fl.bcast & ~st_q.fl.ccc;
    assign wr_in_ccc = st_q.fl.ccc | wr_opens;
    assign wr_code   = wr_opens ? ev_wdata : st_q.code;

    hub_nak_merge #(.N(N_TGT)) u_merge (
        .part   (st_q.part),
        .nak    (tgt_wr_nak),
        .in_ccc (wr_in_ccc),
        .code   (wr_code),
        .nack   (wr_nack)
    );

    always_comb begin
        logic             is_bc;
        logic [N_TGT-1:0] nxt_part;
        st_d         = st_q;
        st_d.rvalid  = 1'b0;
        st_d.p_start = '0;
        st_d.p_wr    = '0;
        st_d.p_stop  = '0;
        st_d.p_nack  = '0;
        is_bc        = (ev_addr == BCAST_ADDR);
        nxt_part     = '0;
        if (ev_start) begin
            if (st_q.fl.daa) begin
                nxt_part = is_bc ? lowest_match : '0;
            end else begin
                nxt_part = tgt_match;
            end
            st_d.fl.bcast = is_bc;
            if (is_bc && !st_q.fl.daa) begin
                st_d.fl.ccc = 1'b0;
            end
            st_d.part    = nxt_part;
            st_d.p_start = nxt_part;
            st_d.rvalid  = 1'b1;
            st_d.rnack   = (nxt_part == '0);
        end else if (ev_stop) begin
            st_d.p_stop = st_q.fl.daa ? ALL_TGT : st_q.part;
            st_d.part   = '0;
            st_d.fl     = '0;
            st_d.code   = '0;
        end else if (ev_write) begin
            if (wr_opens) begin
                st_d.code   = ev_wdata;
                st_d.fl.ccc = 1'b1;
                if (ev_wdata == DAA_CODE) begin
                    st_d.fl.daa = 1'b1;
                end
            end
            st_d.p_wr   = st_q.part;
            st_d.wdat   = ev_wdata;
            st_d.wccc   = wr_in_ccc;
            st_d.rvalid = 1'b1;
            st_d.rnack  = wr_nack;
        end else if (ev_read) begin
            st_d.rdat   = mux_byte;
            st_d.rvalid = 1'b1;
            st_d.rnack  = 1'b0;
        end else if (ev_nack) begin
            st_d.p_nack = st_q.part;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RST_ST;
        end else begin
            st_q <= st_d;
        end
    end

    assign resp_valid   = st_q.rvalid;
    assign resp_nack    = st_q.rnack;
    assign rd_data      = st_q.rdat;
    assign tgt_start    = st_q.p_start;
    assign tgt_wr       = st_q.p_wr;
    assign tgt_wdata    = st_q.wdat;
    assign tgt_ccc_mode = st_q.wccc;
    assign tgt_stop     = st_q.p_stop;
    assign tgt_nack_ev  = st_q.p_nack;
    assign busy         = |st_q.part;
    assign bus_bcast    = st_q.fl.bcast;
    assign bus_ccc      = st_q.fl.ccc;
    assign bus_daa      = st_q.fl.daa;
    assign bus_ccc_code = st_q.code;
endmodule

// File: rtl/hub_route_chk.sv
module hub_route_chk
    import hub_pkg::*;
#(
    parameter int N_TGT = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    ev_start,
    input logic [ADDR_W-1:0]       ev_addr,
    input logic                    ev_write,
    input logic                    ev_read,
    input logic                    ev_stop,
    input logic [N_TGT-1:0]        tgt_match,
    input logic                    resp_valid,
    input logic                    resp_nack,
    input logic [BYTE_W-1:0]       rd_data,
    input logic [N_TGT-1:0]        tgt_start,
    input logic                    busy,
    input logic                    bus_bcast,
    input logic                    bus_ccc,
    input logic                    bus_daa
);
    assert_plain_start_clears_bcast_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_start && ev_addr != BCAST_ADDR) |=> !bus_bcast);

    assert_nomatch_nacked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_start && tgt_match == '0) |=> (resp_valid && resp_nack && !busy));

    assert_daa_implies_ccc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_daa |-> bus_ccc);

    assert_daa_single_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_start && bus_daa) |=> $onehot0(tgt_start));

    assert_idle_read_ff_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_read && !ev_start && !ev_stop && !ev_write && !busy) |=> (rd_data == IDLE_READ));

    assert_stop_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_stop && !ev_start) |=> (!bus_bcast && !bus_ccc && !bus_daa && !busy));
endmodule

bind tgt_route_hub hub_route_chk #(.N_TGT(N_TGT)) u_chk (.*);

// File: tb/tgt_route_hub_bench.sv
module tgt_route_hub_bench;
    localparam int N = 4;
    localparam int NV = 22;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ev_start = 0, ev_write = 0, ev_read = 0, ev_stop = 0, ev_nack = 0;
    logic [6:0] ev_addr = '0;
    logic [7:0] ev_wdata = '0;
    logic [N-1:0] tgt_match = '0, tgt_wr_nak = '0;
    logic [N*8-1:0] tgt_rdata;
    logic resp_valid, resp_nack, tgt_ccc_mode, busy, bus_bcast, bus_ccc, bus_daa;
    logic [7:0] rd_data, tgt_wdata, bus_ccc_code;
    logic [N-1:0] tgt_start, tgt_wr, tgt_stop, tgt_nack_ev;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    // Target i reads back 0xA0 + i.
    for (genvar i = 0; i < N; i++) begin : g_rd
        assign tgt_rdata[i*8 +: 8] = 8'hA0 + 8'(i);
    end

    tgt_route_hub #(.N_TGT(N)) u_tgt_route_hub (.*);

    // op: 0 START, 1 WRITE, 2 READ, 3 STOP, 4 NACK
    // {op, arg, match, nak, exp_nack, exp_mask, exp_rd, exp_bcast, exp_ccc, exp_daa, exp_busy}
    localparam logic [35:0] VEC [NV] = '{
        {3'd0, 8'h7E, 4'hF, 4'h0, 1'b0, 4'hF, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1}, // R2 R3
        {3'd1, 8'h07, 4'h0, 4'h0, 1'b0, 4'hF, 8'h00, 1'b1, 1'b1, 1'b1, 1'b1}, // R4 R7
        {3'd2, 8'h00, 4'h0, 4'h0, 1'b0, 4'h0, 8'hA0, 1'b1, 1'b1, 1'b1, 1'b1}, // R9
        {3'd1, 8'h55, 4'h0, 4'h0, 1'b0, 4'hF, 8'h00, 1'b1, 1'b1, 1'b1, 1'b1}, // R7
        {3'd0, 8'h7E, 4'hE, 4'h0, 1'b0, 4'h2, 8'h00, 1'b1, 1'b1, 1'b1, 1'b1}, // R5 R6
        {3'd2, 8'h00, 4'h0, 4'h0, 1'b0, 4'h0, 8'hA1, 1'b1, 1'b1, 1'b1, 1'b1}, // R9
        {3'd0, 8'h30, 4'h1, 4'h0, 1'b1, 4'h0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0}, // R6
        {3'd3, 8'h00, 4'h0, 4'h0, 1'b0, 4'hF, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0}, // R10
        {3'd0, 8'h7E, 4'hF, 4'h0, 1'b0, 4'hF, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1}, // R3
        {3'd1, 8'h01, 4'h0, 4'h4, 1'b0, 4'hF, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1}, // R8
        {3'd0, 8'h7E, 4'hF, 4'h0, 1'b0, 4'hF, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1}, // R5
        {3'd1, 8'h9A, 4'h0, 4'h0, 1'b0, 4'hF, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1}, // R4
        {3'd0, 8'h12, 4'h4, 4'h0, 1'b0, 4'h4, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1}, // R5
        {3'd1, 8'h33, 4'h0, 4'h4, 1'b1, 4'h4, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1}, // R8
        {3'd3, 8'h00, 4'h0, 4'h0, 1'b0, 4'h4, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0}, // R10
        {3'd0, 8'h22, 4'h0, 4'h0, 1'b1, 4'h0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0}, // R3
        {3'd2, 8'h00, 4'h0, 4'h0, 1'b0, 4'h0, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b0}, // R9
        {3'd0, 8'h22, 4'hA, 4'h0, 1'b0, 4'hA, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1}, // R3 R12
        {3'd1, 8'h44, 4'h0, 4'h8, 1'b1, 4'hA, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1}, // R8
        {3'd2, 8'h00, 4'h0, 4'h0, 1'b0, 4'h0, 8'hA1, 1'b0, 1'b0, 1'b0, 1'b1}, // R9
        {3'd4, 8'h00, 4'h0, 4'h0, 1'b0, 4'hA, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1}, // R11
        {3'd3, 8'h00, 4'h0, 4'h0, 1'b0, 4'hA, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0}  // R10
    };

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic apply(input logic [2:0] op, input logic [7:0] arg,
                         input logic [3:0] m, input logic [3:0] nk);
        @(negedge clk);
        ev_addr = arg[6:0]; ev_wdata = arg; tgt_match = m; tgt_wr_nak = nk;
        ev_start = (op == 3'd0); ev_write = (op == 3'd1); ev_read = (op == 3'd2);
        ev_stop = (op == 3'd3); ev_nack = (op == 3'd4);
        @(negedge clk);
        ev_start = 0; ev_write = 0; ev_read = 0; ev_stop = 0; ev_nack = 0;
        tgt_match = '0; tgt_wr_nak = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check({bus_bcast, bus_ccc, bus_daa, busy, resp_valid, resp_nack} == 6'b0, "R1", "flags",
              {bus_bcast, bus_ccc, bus_daa, busy, resp_valid, resp_nack}, 0);
        check({tgt_start, tgt_wr, tgt_stop, tgt_nack_ev} == '0, "R1", "pulses",
              {tgt_start, tgt_wr, tgt_stop, tgt_nack_ev}, 0);
        check(rd_data == 8'hFF && bus_ccc_code == 8'h00, "R1", "rd/code",
              {rd_data, bus_ccc_code}, 16'hFF00);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            logic [35:0] e;
            logic [2:0] op;
            logic [N-1:0] msk;
            bit ok;
            e = VEC[v];
            op = e[35:33];
            apply(op, e[32:25], e[24:21], e[20:17]);
            case (op)
                3'd0: msk = tgt_start;
                3'd1: msk = tgt_wr;
                3'd3: msk = tgt_stop;
                3'd4: msk = tgt_nack_ev;
                default: msk = tgt_start | tgt_wr | tgt_stop | tgt_nack_ev;
            endcase
            ok = (msk == e[15:12]) &&
                 ({bus_bcast, bus_ccc, bus_daa, busy} == e[3:0]);
            if (op <= 3'd2) ok = ok && resp_valid && (resp_nack == e[16]);
            if (op == 3'd1) ok = ok && (tgt_wdata == e[32:25]) && (tgt_ccc_mode == e[2]);
            if (op == 3'd2) ok = ok && (rd_data == e[11:4]);
            check(ok, "R2-R12 vector", $sformatf("v%0d op%0d mask/nack/rd/flags", v, op),
                  {msk, resp_nack, rd_data, bus_bcast, bus_ccc, bus_daa, busy},
                  {e[15:12], e[16], e[11:4], e[3:0]});
        end

        // R4 code capture and R10 code clear
        apply(3'd0, 8'h7E, 4'h3, 4'h0);
        apply(3'd1, 8'h2B, 4'h0, 4'h0);
        check(bus_ccc_code == 8'h2B, "R4", "ccc code", bus_ccc_code, 8'h2B);
        // R4: a later byte of the same command does not replace the code
        apply(3'd1, 8'h66, 4'h0, 4'h0);
        check(bus_ccc_code == 8'h2B && tgt_ccc_mode, "R4", "code held", bus_ccc_code, 8'h2B);
        // R11: NACK event keeps the participants
        apply(3'd4, 8'h00, 4'h0, 4'h0);
        check(busy && tgt_nack_ev == 4'h3, "R11", "set kept", {busy, tgt_nack_ev}, 5'h13);
        apply(3'd3, 8'h00, 4'h0, 4'h0);
        check(bus_ccc_code == 8'h00 && tgt_stop == 4'h3, "R10", "stop/code",
              {tgt_stop, bus_ccc_code}, 12'h300);
        // R7: private write is not in a command; pulses last one cycle
        apply(3'd0, 8'h15, 4'h8, 4'h0);
        apply(3'd1, 8'h5A, 4'h0, 4'h0);
        check(!tgt_ccc_mode && tgt_wr == 4'h8 && !resp_nack, "R7", "private write",
              {tgt_ccc_mode, tgt_wr}, 5'h08);
        @(negedge clk);
        check(tgt_wr == 4'h0 && !resp_valid, "R7", "pulse width", {tgt_wr, resp_valid}, 0);
        apply(3'd3, 8'h00, 4'h0, 4'h0);
        check(!busy, "R12", "busy after stop", busy, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule